// File: doc/BRIEF.md
# Dual-Byte 8b/10b Receive Decoder

This block turns a pair of 10-bit line symbols into a 16-bit word in each clock, with one control flag per byte. It sits after the deserializer and word aligner. The low symbol is the earlier one in time. The block keeps the running disparity across symbols and across pairs. It accepts a symbol only if a conforming encoder could have produced it at the current disparity. The one exception is the three comma characters.

Faults are reported in-band and per byte. A byte whose symbol is not acceptable comes out as the invalid control character K0.0, and the neighbouring byte still decodes normally. While the line reports loss of signal, both bytes come out as the invalid control character K31.7. A separate per-byte pulse marks a comma in its negative-disparity form, so downstream logic can use it to align words. Results are registered one clock after the input pair.

Top module: `rx8b10b_pair_decoder`

## Requirements
- R1: While rst_ni is low at a clock edge, the outputs clear to data 0x0000, k 0, err 0 and comma 0, and the running disparity (RD) returns to negative.
- R2: When sym_valid_i is high and los_i is low, a valid pair appears on the outputs at the next clock edge. Lane 0 is sym_i[9:0] and is the earlier symbol; it maps to data_o[7:0]. In each symbol, bit 9 is the first line bit of the 6-bit sub-block and bit 0 is the last bit of the 4-bit sub-block. Each byte is laid out HGF EDCBA with bit 7 = H. For a data character, k and err are 0.
- R3: The only control characters accepted are K28.0 to K28.7 (0x1C, 0x3C, ..., 0xFC), K23.7 (0xF7), K27.7 (0xFB), K29.7 (0xFD) and K30.7 (0xFE). Each is output with its k bit set and err clear.
- R4: Lane 0 is checked against the RD held from the previous pair. Lane 1 is checked against the RD that follows lane 0. The RD after lane 1 is carried to the next pair.
- R5: A symbol is a byte error if it is unknown, has the wrong disparity form, or is a control character outside the R3 set. That byte alone outputs K0.0: k 1, data 0x00, err 1. The other byte is unaffected.
- R6: RD advances on every accepted symbol, errors included, one sub-block at a time. A sub-block with more ones than zeros makes RD positive, and one with fewer makes it negative. A balanced sub-block leaves RD unchanged, except that 111000 and 1100 make it negative and 000111 and 0011 make it positive.
- R7: K28.1, K28.5 and K28.7 decode as valid control characters in either disparity form, whatever the current RD.
- R8: comma_o[n] is high for one clock when lane n carried K28.1, K28.5 or K28.7 in its negative-RD form, that is, with 6-bit sub-block 001111.
- R9: While los_i is high, whatever sym_valid_i is, both bytes output K31.7 at the next edge (k 1, data 0xFF, err 1) with comma 0, and RD returns to negative.
- R10: When sym_valid_i and los_i are both low, data, k and err hold their values, comma goes to 0 and RD does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| sym_i | input | 20 | Two 10-bit symbols; lane 0 in bits 9:0 is the earlier |
| sym_valid_i | input | 1 | The symbol pair is present this cycle |
| los_i | input | 1 | Loss of signal from the line |
| data_o | output | 16 | Decoded bytes, lane 0 in bits 7:0 |
| k_o | output | 2 | Control-character flag per byte |
| err_o | output | 2 | Byte replaced by an error character |
| comma_o | output | 2 | Negative-form comma received on that byte |

## Verification
The hardest states to reach are those where the decoder's disparity differs from the disparity the stimulus would naturally produce. Examples are a comma arriving in the form that does not match the current RD, and a state reached only by the RD update from a corrupt symbol. The bench tracks RD alongside the design. It forces positive RD with chosen byte pairs and then injects raw symbol patterns: comma forms of the opposite polarity, a wrong-form data symbol, and unsupported control patterns. It then sends a cleanly encoded pair, so that any error in the design's RD shows up as a spurious K0.0.

// File: rtl/rx8b10b_pkg.sv
// Package: shared widths, lane result type and the 8b/10b code functions.
// Assumes symbol bit 9 is line bit "a" and bit 0 is line bit "j".
// RD is encoded as one bit: 1 = positive, 0 = negative.
package rx8b10b_pkg;

    localparam int SYM_W  = 10;
    localparam int BYTE_W = 8;
    localparam int HI_W   = 6;
    localparam int LO_W   = 4;

    typedef struct packed {
        logic [BYTE_W-1:0] value;
        logic              is_ctrl;
        logic              bad;
        logic              comma;
    } lane_res_t;

    // 6-bit code of data value x in its negative-RD form
    function automatic logic [HI_W-1:0] six_neg(input logic [4:0] x);
        case (x)
            5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
            5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
            5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
            5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
            5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
            5'd10: return 6'b010101;  5'd11: return 6'b110100;
            5'd12: return 6'b001101;  5'd13: return 6'b101100;
            5'd14: return 6'b011100;  5'd15: return 6'b010111;
            5'd16: return 6'b011011;  5'd17: return 6'b100011;
            5'd18: return 6'b010011;  5'd19: return 6'b110010;
            5'd20: return 6'b001011;  5'd21: return 6'b101010;
            5'd22: return 6'b011010;  5'd23: return 6'b111010;
            5'd24: return 6'b110011;  5'd25: return 6'b100110;
            5'd26: return 6'b010110;  5'd27: return 6'b110110;
            5'd28: return 6'b001110;  5'd29: return 6'b101110;
            5'd30: return 6'b011110;  default: return 6'b101011;
        endcase
    endfunction

    // 6-bit data code at a given RD
    function automatic logic [HI_W-1:0] six_code(input logic [4:0] x, input logic pos);
        logic [HI_W-1:0] n;
        n = six_neg(x);
        if (pos && (($countones(n) != 3) || (n == 6'b111000))) return ~n;
        return n;
    endfunction

    // 6-bit sub-block of K28 at a given RD
    function automatic logic [HI_W-1:0] six_k28(input logic pos);
        return pos ? 6'b110000 : 6'b001111;
    endfunction

    // 4-bit data code, with the alternate y=7 form where required
    function automatic logic [LO_W-1:0] four_data(input logic [2:0] y, input logic pos,
                                                  input logic [4:0] x);
        logic [LO_W-1:0] n;
        logic            alt;
        alt = (y == 3'd7) && (pos ? (x == 5'd11 || x == 5'd13 || x == 5'd14)
                                  : (x == 5'd17 || x == 5'd18 || x == 5'd20));
        case (y)
            3'd0: n = 4'b1011;  3'd1: n = 4'b1001;
            3'd2: n = 4'b0101;  3'd3: n = 4'b1100;
            3'd4: n = 4'b1101;  3'd5: n = 4'b1010;
            3'd6: n = 4'b0110;  default: n = alt ? 4'b0111 : 4'b1110;
        endcase
        if (pos && (($countones(n) != 2) || (n == 4'b1100))) return ~n;
        return n;
    endfunction

    // 4-bit sub-block of a control character at a given RD
    function automatic logic [LO_W-1:0] four_ctrl(input logic [2:0] y, input logic pos);
        logic [LO_W-1:0] n;
        case (y)
            3'd0: n = 4'b1011;  3'd1: n = 4'b0110;
            3'd2: n = 4'b1010;  3'd3: n = 4'b1100;
            3'd4: n = 4'b1101;  3'd5: n = 4'b0101;
            3'd6: n = 4'b1001;  default: n = 4'b0111;
        endcase
        return pos ? ~n : n;
    endfunction

    // RD after a 6-bit sub-block, applied to any pattern
    function automatic logic rd_after6(input logic [HI_W-1:0] c, input logic pos);
        if ($countones(c) > 3) return 1'b1;
        if ($countones(c) < 3) return 1'b0;
        if (c == 6'b111000)    return 1'b0;
        if (c == 6'b000111)    return 1'b1;
        return pos;
    endfunction

    // RD after a 4-bit sub-block, applied to any pattern
    function automatic logic rd_after4(input logic [LO_W-1:0] c, input logic pos);
        if ($countones(c) > 2) return 1'b1;
        if ($countones(c) < 2) return 1'b0;
        if (c == 4'b1100)      return 1'b0;
        if (c == 4'b0011)      return 1'b1;
        return pos;
    endfunction

    // 5-bit values that are legal with y=7 as control characters
    function automatic logic ext_ctrl(input logic [4:0] x);
        return (x == 5'd23) || (x == 5'd27) || (x == 5'd29) || (x == 5'd30);
    endfunction

endpackage

// File: rtl/rx8b10b_lane_dec.sv
// Lane decoder: combinational check and decode of one 10-bit symbol.
// Takes the RD in force before the symbol and returns the RD after it.
// A rejected symbol yields K0.0 with bad set. Comma forms are exempt
// from the disparity check.
module rx8b10b_lane_dec
    import rx8b10b_pkg::*;
(
    input  logic [SYM_W-1:0] sym_i,
    input  logic             rd_i,
    output lane_res_t        res_o,
    output logic             rd_o
);

    logic [HI_W-1:0] hi6;
    logic [LO_W-1:0] lo4;
    logic            hit6, hit4d, hitk, k28_cur, k28_opp, rd_mid;
    logic [4:0]      x;
    logic [2:0]      yd, yk;
    logic            ok_data, ok_ext, ok_k28, comma_y;

    assign hi6 = sym_i[SYM_W-1:LO_W];
    assign lo4 = sym_i[LO_W-1:0];

    // search the sub-block tables at the relevant disparities
    always_comb begin
        hit6 = 1'b0;
        x    = '0;
        for (int i = 0; i < 32; i++) begin
            if (six_code(5'(i), rd_i) == hi6) begin
                hit6 = 1'b1;
                x    = 5'(i);
            end
        end
        k28_cur = (hi6 == six_k28(rd_i));
        k28_opp = (hi6 == six_k28(!rd_i));
        rd_mid  = rd_after6(hi6, rd_i);
        hit4d   = 1'b0;
        yd      = '0;
        hitk    = 1'b0;
        yk      = '0;
        for (int j = 0; j < 8; j++) begin
            if (four_data(3'(j), rd_mid, x) == lo4) begin
                hit4d = 1'b1;
                yd    = 3'(j);
            end
            if (four_ctrl(3'(j), rd_mid) == lo4) begin
                hitk = 1'b1;
                yk   = 3'(j);
            end
        end
    end

    // classify the symbol and form the lane result
    always_comb begin
        comma_y = (yk == 3'd1) || (yk == 3'd5) || (yk == 3'd7);
        ok_data = hit6 && hit4d;
        ok_ext  = hit6 && ext_ctrl(x) && hitk && (yk == 3'd7);
        ok_k28  = hitk && (k28_cur || (k28_opp && comma_y));
        res_o   = '0;
        if (ok_data) begin
            res_o.value = {yd, x};
        end else if (ok_ext) begin
            res_o.value   = {3'd7, x};
            res_o.is_ctrl = 1'b1;
        end else if (ok_k28) begin
            res_o.value   = {yk, 5'd28};
            res_o.is_ctrl = 1'b1;
            res_o.comma   = comma_y && (hi6 == 6'b001111);
        end else begin
            res_o.is_ctrl = 1'b1;
            res_o.bad     = 1'b1;
        end
        rd_o = rd_after4(lo4, rd_mid);
    end

endmodule

// File: rtl/rx8b10b_out_stage.sv
// Output stage: registers the lane results, forces K31.7 on loss of
// signal, holds the bytes when no pair is offered, and lets the comma
// flags last a single cycle.
module rx8b10b_out_stage
    import rx8b10b_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  lane_res_t [LANES-1:0]    res_i,
    input  logic                     valid_i,
    input  logic                     los_i,
    output logic [LANES*BYTE_W-1:0]  data_o,
    output logic [LANES-1:0]         k_o,
    output logic [LANES-1:0]         err_o,
    output logic [LANES-1:0]         comma_o
);

    // output register update
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            data_o  <= '0;
            k_o     <= '0;
            err_o   <= '0;
            comma_o <= '0;
        end else if (los_i) begin
            data_o  <= '1;
            k_o     <= '1;
            err_o   <= '1;
            comma_o <= '0;
        end else if (valid_i) begin
            for (int n = 0; n < LANES; n++) begin
                data_o[n*BYTE_W +: BYTE_W] <= res_i[n].value;
                k_o[n]                     <= res_i[n].is_ctrl;
                err_o[n]                   <= res_i[n].bad;
                comma_o[n]                 <= res_i[n].comma;
            end
        end else begin
            comma_o <= '0;
        end
    end

    p_los_force_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        los_i |=> (data_o == '1) && (k_o == '1) && (err_o == '1) && (comma_o == '0));

    p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!valid_i && !los_i) |=> $stable(data_o) && $stable(k_o) && $stable(err_o)
                                 && (comma_o == '0));

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        p_err_char_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            err_o[g] |-> k_o[g] && ((data_o[g*BYTE_W +: BYTE_W] == '0)
                                    || (data_o[g*BYTE_W +: BYTE_W] == '1)));

        p_comma_char_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            comma_o[g] |-> k_o[g] && !err_o[g]
                           && ((data_o[g*BYTE_W +: BYTE_W] == 8'h3C)
                               || (data_o[g*BYTE_W +: BYTE_W] == 8'hBC)
                               || (data_o[g*BYTE_W +: BYTE_W] == 8'hFC)));
    end

endmodule

// File: rtl/rx8b10b_pair_decoder.sv
// Top: decodes LANES symbols per clock (default two). The lanes are
// chained through the running disparity, lane 0 first in time. The RD
// register resets to negative, is cleared on loss of signal and
// advances only on a valid pair.
module rx8b10b_pair_decoder
    import rx8b10b_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [LANES*SYM_W-1:0]   sym_i,
    input  logic                     sym_valid_i,
    input  logic                     los_i,
    output logic [LANES*BYTE_W-1:0]  data_o,
    output logic [LANES-1:0]         k_o,
    output logic [LANES-1:0]         err_o,
    output logic [LANES-1:0]         comma_o
);

    logic                    rd_q;
    logic [LANES:0]          rd_chain;
    lane_res_t [LANES-1:0]   lane_res;

    assign rd_chain[0] = rd_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rx8b10b_lane_dec u_lane (
            .sym_i (sym_i[g*SYM_W +: SYM_W]),
            .rd_i  (rd_chain[g]),
            .res_o (lane_res[g]),
            .rd_o  (rd_chain[g+1])
        );
    end

    // running disparity carried from pair to pair
    always_ff @(posedge clk_i) begin
        if (!rst_ni || los_i) rd_q <= 1'b0;
        else if (sym_valid_i) rd_q <= rd_chain[LANES];
    end

    rx8b10b_out_stage #(.LANES(LANES)) u_out (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .res_i   (lane_res),
        .valid_i (sym_valid_i),
        .los_i   (los_i),
        .data_o  (data_o),
        .k_o     (k_o),
        .err_o   (err_o),
        .comma_o (comma_o)
    );

    p_rd_los_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        los_i |=> (rd_q == 1'b0));

    p_rd_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sym_valid_i && !los_i) |=> $stable(rd_q));

endmodule

// File: tb/rx8b10b_pair_decoder_tb.sv
module rx8b10b_pair_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] sym = '0;
    logic        vld = 1'b0;
    logic        los = 1'b0;
    logic [15:0] data_o;
    logic [1:0]  k_o, err_o, comma_o;
    int          total = 0;
    int          bad = 0;
    logic        rd_tx = 1'b0;

    always #5 clk = ~clk;

    rx8b10b_pair_decoder u_dut (
        .clk_i(clk), .rst_ni(rst_n), .sym_i(sym), .sym_valid_i(vld), .los_i(los),
        .data_o(data_o), .k_o(k_o), .err_o(err_o), .comma_o(comma_o)
    );

    function automatic logic [5:0] tb6(input logic [4:0] x);
        case (x)
            0: return 6'b100111;  1: return 6'b011101;  2: return 6'b101101;
            3: return 6'b110001;  4: return 6'b110101;  5: return 6'b101001;
            6: return 6'b011001;  7: return 6'b111000;  8: return 6'b111001;
            9: return 6'b100101; 10: return 6'b010101; 11: return 6'b110100;
           12: return 6'b001101; 13: return 6'b101100; 14: return 6'b011100;
           15: return 6'b010111; 16: return 6'b011011; 17: return 6'b100011;
           18: return 6'b010011; 19: return 6'b110010; 20: return 6'b001011;
           21: return 6'b101010; 22: return 6'b011010; 23: return 6'b111010;
           24: return 6'b110011; 25: return 6'b100110; 26: return 6'b010110;
           27: return 6'b110110; 28: return 6'b001110; 29: return 6'b101110;
           30: return 6'b011110; default: return 6'b101011;
        endcase
    endfunction

    function automatic logic [3:0] tbd4(input logic [2:0] y);
        case (y)
            0: return 4'b1011; 1: return 4'b1001; 2: return 4'b0101; 3: return 4'b1100;
            4: return 4'b1101; 5: return 4'b1010; 6: return 4'b0110; default: return 4'b1110;
        endcase
    endfunction

    function automatic logic [3:0] tbk4(input logic [2:0] y);
        case (y)
            0: return 4'b1011; 1: return 4'b0110; 2: return 4'b1010; 3: return 4'b1100;
            4: return 4'b1101; 5: return 4'b0101; 6: return 4'b1001; default: return 4'b0111;
        endcase
    endfunction

    // transmit-side encoder: returns {rd_after, symbol}
    function automatic logic [10:0] tx_enc(input logic [7:0] b, input logic k, input logic rd);
        logic [4:0] x; logic [2:0] y; logic [5:0] c6; logic [3:0] c4; logic r;
        x = b[4:0]; y = b[7:5];
        c6 = (k && x == 5'd28) ? 6'b001111 : tb6(x);
        if (rd && ((k && x == 5'd28) || $countones(c6) != 3 || c6 == 6'b111000)) c6 = ~c6;
        r = ($countones(c6) == 3) ? rd : ~rd;
        if (k) begin
            c4 = r ? ~tbk4(y) : tbk4(y);
        end else if (y == 3'd7 && (r ? (x == 5'd11 || x == 5'd13 || x == 5'd14)
                                     : (x == 5'd17 || x == 5'd18 || x == 5'd20))) begin
            c4 = r ? 4'b1000 : 4'b0111;
        end else begin
            c4 = tbd4(y);
            if (r && ($countones(c4) != 2 || c4 == 4'b1100)) c4 = ~c4;
        end
        if ($countones(c4) != 2) r = ~r;
        return {r, c6, c4};
    endfunction

    // RD rule of R6 applied to an arbitrary symbol
    function automatic logic rx_rd(input logic [9:0] s, input logic rd);
        logic r;
        r = rd;
        if ($countones(s[9:4]) > 3) r = 1'b1;
        else if ($countones(s[9:4]) < 3) r = 1'b0;
        else if (s[9:4] == 6'b111000) r = 1'b0;
        else if (s[9:4] == 6'b000111) r = 1'b1;
        if ($countones(s[3:0]) > 2) r = 1'b1;
        else if ($countones(s[3:0]) < 2) r = 1'b0;
        else if (s[3:0] == 4'b1100) r = 1'b0;
        else if (s[3:0] == 4'b0011) r = 1'b1;
        return r;
    endfunction

    task automatic step(input logic [9:0] lo, input logic [9:0] hi, input logic v, input logic l);
        @(negedge clk);
        sym = {hi, lo}; vld = v; los = l;
        @(posedge clk);
        #2;
    endtask

    task automatic check(input logic [15:0] ed, input logic [1:0] ek, input logic [1:0] ee,
                         input logic [1:0] ec, input string req);
        total++;
        if (data_o !== ed || k_o !== ek || err_o !== ee || comma_o !== ec) begin
            bad++;
            $display("FAIL %s: data=%h k=%b err=%b comma=%b expected data=%h k=%b err=%b comma=%b",
                     req, data_o, k_o, err_o, comma_o, ed, ek, ee, ec);
        end
    endtask

    function automatic logic is_comma(input logic [7:0] b, input logic k);
        return k && (b == 8'h3C || b == 8'hBC || b == 8'hFC);
    endfunction

    task automatic run_pair(input logic [7:0] bl, input logic kl, input logic [7:0] bh,
                            input logic kh, input string req);
        logic [10:0] el, eh; logic [1:0] ec;
        el = tx_enc(bl, kl, rd_tx);
        ec[0] = is_comma(bl, kl) && !rd_tx;
        eh = tx_enc(bh, kh, el[10]);
        ec[1] = is_comma(bh, kh) && !el[10];
        rd_tx = eh[10];
        step(el[9:0], eh[9:0], 1'b1, 1'b0);
        check({bh, bl}, {kh, kl}, 2'b00, ec, req);
    endtask

    // entries: {k_hi, byte_hi, k_lo, byte_lo}
    localparam logic [17:0] VEC [16] = '{
        {1'b0, 8'h00, 1'b0, 8'h00}, {1'b0, 8'hFF, 1'b0, 8'hAA},
        {1'b1, 8'hBC, 1'b0, 8'h55}, {1'b1, 8'h3C, 1'b1, 8'hBC},
        {1'b0, 8'hF1, 1'b0, 8'hF2}, {1'b0, 8'hEB, 1'b0, 8'hED},
        {1'b1, 8'hF7, 1'b1, 8'hFB}, {1'b1, 8'hFD, 1'b1, 8'hFE},
        {1'b1, 8'h1C, 1'b1, 8'h7C}, {1'b1, 8'h5C, 1'b1, 8'h9C},
        {1'b1, 8'hDC, 1'b1, 8'hFC}, {1'b0, 8'h07, 1'b0, 8'h87},
        {1'b0, 8'h1C, 1'b0, 8'hE7}, {1'b1, 8'hBC, 1'b1, 8'hBC},
        {1'b0, 8'h34, 1'b0, 8'h12}, {1'b0, 8'hEE, 1'b0, 8'hF4}
    };

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [9:0] s_lo, s_hi;
        logic [10:0] e;
        logic r;
        repeat (3) @(posedge clk);
        #2;
        check(16'h0000, 2'b00, 2'b00, 2'b00, "R1 reset outputs");
        @(negedge clk); rst_n = 1'b1;

        // table walk: R2, R3, R4, R8 (first entry also relies on R1 RD reset)
        for (int i = 0; i < 16; i++)
            run_pair(VEC[i][7:0], VEC[i][8], VEC[i][16:9], VEC[i][17], "R2,R3,R4,R8 table");

        // R5/R6: garbage on low lane only
        s_lo = 10'b0;
        r = rx_rd(s_lo, rd_tx);
        e = tx_enc(8'h5A, 1'b0, r);
        rd_tx = e[10];
        step(s_lo, e[9:0], 1'b1, 1'b0);
        check(16'h5A00, 2'b01, 2'b01, 2'b00, "R5 low byte error");

        // R5: high lane in the wrong disparity form
        e = tx_enc(8'h33, 1'b0, rd_tx);
        s_lo = e[9:0];
        e = tx_enc(8'h00, 1'b0, ~e[10]);
        s_hi = e[9:0];
        rd_tx = rx_rd(s_hi, rx_rd(s_lo, rd_tx));
        step(s_lo, s_hi, 1'b1, 1'b0);
        check(16'h0033, 2'b10, 2'b10, 2'b00, "R5 disparity error high byte");

        // R5: unsupported control patterns on both lanes
        s_lo = {6'b000000, 4'b0110};
        s_hi = {6'b101010, 4'b0111};
        rd_tx = rx_rd(s_hi, rx_rd(s_lo, rd_tx));
        step(s_lo, s_hi, 1'b1, 1'b0);
        check(16'h0000, 2'b11, 2'b11, 2'b00, "R5 unsupported control");
        run_pair(8'h47, 1'b0, 8'hC9, 1'b0, "R6 RD after corrupt symbols");

        // R7/R8: negative-form comma while RD is positive
        if (!rd_tx) run_pair(8'h21, 1'b0, 8'h23, 1'b0, "R4 force positive RD");
        s_lo = 10'b0011111010;
        r = rx_rd(s_lo, rd_tx);
        e = tx_enc(8'hBC, 1'b1, r);
        rd_tx = e[10];
        step(s_lo, e[9:0], 1'b1, 1'b0);
        check(16'hBCBC, 2'b11, 2'b00, 2'b01, "R7,R8 comma opposite RD");

        // R10: idle cycle holds, clears comma, keeps RD
        step(10'h3FF, 10'h3FF, 1'b0, 1'b0);
        check(16'hBCBC, 2'b11, 2'b00, 2'b00, "R10 hold when idle");
        run_pair(8'h00, 1'b0, 8'h00, 1'b0, "R10 RD unchanged while idle");

        // R7/R5: positive-form K28.1 at negative RD is valid, K28.0 is not
        s_lo = 10'b1100000110;
        s_hi = 10'b1100001011;
        rd_tx = rx_rd(s_hi, rx_rd(s_lo, rd_tx));
        step(s_lo, s_hi, 1'b1, 1'b0);
        check(16'h003C, 2'b11, 2'b10, 2'b00, "R7,R5 opposite-form K28 pair");

        // R9: loss of signal with and without valid
        if (!rd_tx) run_pair(8'h21, 1'b0, 8'h23, 1'b0, "R4 force positive RD");
        step(10'h155, 10'h2AA, 1'b1, 1'b1);
        check(16'hFFFF, 2'b11, 2'b11, 2'b00, "R9 loss of signal with valid");
        step(10'h000, 10'h000, 1'b0, 1'b1);
        check(16'hFFFF, 2'b11, 2'b11, 2'b00, "R9 loss of signal without valid");
        rd_tx = 1'b0;
        run_pair(8'h21, 1'b0, 8'hBC, 1'b1, "R9 RD negative after loss of signal");

        // R1: reset in mid-run
        if (!rd_tx) run_pair(8'h21, 1'b0, 8'h23, 1'b0, "R4 force positive RD");
        @(negedge clk); rst_n = 1'b0; vld = 1'b0; los = 1'b0;
        @(posedge clk); #2;
        check(16'h0000, 2'b00, 2'b00, 2'b00, "R1 reset mid-run");
        @(negedge clk); rst_n = 1'b1;
        rd_tx = 1'b0;
        run_pair(8'h21, 1'b0, 8'hBC, 1'b1, "R1 RD negative after reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule